// File: doc/BRIEF.md
# Triggered Frame-Reset Acquisition Sequencer

This block runs one triggered capture inside a video acquisition timing generator. While idle it keeps the line and field counting held in vertical blank. An external trigger arrives asynchronously. It passes through a synchroniser and an edge detector, and when the block is armed the trigger opens a capture cycle. The cycle first drives a reset pulse to the camera, with a selectable polarity and width. It also drives a matching reset to the local vertical-sync generator. It then waits a programmable number of extra lines before the line counter starts. This extra wait happens once per cycle and only ahead of the first field.

After the wait, the sequencer walks one, two or three fields of programmable length. The field count depends on the capture mode. During the active lines of each field that is captured, it raises an acquire enable for the video memory. In the first field it emits a single strobe line at a programmed line number. When the last field ends, the block returns to idle and waits for the next trigger. Line ticks come from the horizontal timing logic as one-cycle pulses. All configuration inputs are expected to stay stable while a cycle runs.

Top module: `frame_reset_sequencer`

## Requirements
- R1: After reset the block is idle. `st_busy`, `acq_en`, `strobe_out` and `vs_reset` are 0, and `frst_out` sits at its inactive level, which is the inverse of `cfg_pulse_pol`.
- R2: A rising edge on `trig_in` starts a cycle only when `cfg_arm` is 1. `st_busy` goes high on the third rising clock edge after the input changes: two synchroniser stages plus one edge stage. With `cfg_arm` at 0 the edge has no effect.
- R3: The reset pulse becomes active on the same clock edge that `st_busy` rises. `cfg_pulse_pol` = 1 makes `frst_out` high while active, and 0 makes it low while active. `vs_reset` is high in exactly the lines where the pulse is active.
- R4: With `cfg_wide_pulse` = 0 the pulse lasts one line and ends at the first line tick. With `cfg_wide_pulse` = 1 it lasts `cfg_froff` lines, or one line when `cfg_froff` is 0.
- R5: After the trigger, `cfg_froff` line ticks pass before the field line counter starts at line 0. This delay is applied once per cycle, so a cycle stays busy for `cfg_froff` + fields × `cfg_field_lines` line ticks.
- R6: `cfg_mode` sets the number of fields. Code 0 gives one field, code 1 gives two (interlaced), code 2 gives three (skip-field), and the reserved code 3 gives one.
- R7: `acq_en` is high on field lines `cfg_voff` through `cfg_voff`+`cfg_active`−1 of every captured field. In skip-field mode field 0 is not captured and fields 1 and 2 are. In all other modes every field is captured. `acq_en` is never high while idle or during the extra delay.
- R8: `strobe_out` is high for exactly one line, the line of field 0 whose line number equals `cfg_strobe_line`, and it is low at all other times.
- R9: Trigger edges that arrive while a cycle is in progress are ignored. A trigger held high past the end of a cycle does not start a new one.
- R10: `st_armed` is high when `cfg_arm` is 1 and the block is idle. `st_busy` is high from the trigger until the last line of the last field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | External trigger, asynchronous |
| line_tick | input | 1 | One-cycle pulse at each line start |
| cfg_arm | input | 1 | Allows a trigger to start a cycle |
| cfg_mode | input | 2 | Field mode: 0 single, 1 interlaced, 2 skip-field, 3 single |
| cfg_wide_pulse | input | 1 | 0: one-line reset pulse; 1: pulse of `cfg_froff` lines |
| cfg_pulse_pol | input | 1 | 1: reset pulse active high; 0: active low |
| cfg_froff | input | LW | Extra lines counted before the first field |
| cfg_voff | input | LW | First active line within a field |
| cfg_active | input | LW | Number of active lines per field |
| cfg_strobe_line | input | LW | Field-0 line number that carries the strobe |
| cfg_field_lines | input | LW | Lines per field (at least 1) |
| frst_out | output | 1 | Camera frame-reset pulse |
| vs_reset | output | 1 | Active-high reset to the vertical-sync generator |
| strobe_out | output | 1 | One-line strobe |
| acq_en | output | 1 | Memory acquire enable |
| st_armed | output | 1 | Armed and waiting for a trigger |
| st_busy | output | 1 | Capture cycle in progress |

## Verification
The bench aims at the places where the counts are most likely to slip by one. These are the width of the wide pulse against the delay. A design that restarted the delay on later fields would stay busy for extra lines. A design that started its line counter one tick early would place the strobe and the first acquire line off by one. The bench also covers a zero delay, where the pulse must still last one line. It checks the skip-field mode, where capturing the first field would show up as an early acquire start. It checks that a retrigger mid-cycle and a trigger held high across the end of a cycle do not stretch or restart the cycle. The trigger latency is sampled one edge before and one edge after the expected rise, which catches a missing or extra synchroniser stage.

// File: rtl/frs_pkg.sv
package frs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_DELAY = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_t;

   localparam logic [1:0] MODE_SINGLE = 2'd0;
   localparam logic [1:0] MODE_PAIR   = 2'd1;
   localparam logic [1:0] MODE_SKIP   = 2'd2;

   // index of the last field walked for a given mode code
   function automatic logic [1:0] last_field(input logic [1:0] mode);
      case (mode)
         MODE_PAIR: last_field = 2'd1;
         MODE_SKIP: last_field = 2'd2;
         default:   last_field = 2'd0;
      endcase
   endfunction

   // whether a field index is written to memory in a given mode
   function automatic logic field_captured(input logic [1:0] mode, input logic [1:0] fld);
      field_captured = (mode == MODE_SKIP) ? (fld != 2'd0) : 1'b1;
   endfunction

endpackage

// File: rtl/frs_trig_sync.sv
module frs_trig_sync #(
   parameter int STAGES      = 2,
   parameter bit TRIG_RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_seen
);

   if (STAGES < 2) begin : g_bad_stages
      $error("frs_trig_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], async_in};
   end

   if (TRIG_RISING) begin : g_rise
      assign edge_seen = sh_q[STAGES-1] & ~sh_q[STAGES];
   end else begin : g_fall
      assign edge_seen = ~sh_q[STAGES-1] & sh_q[STAGES];
   end

endmodule

// File: rtl/frs_pulse_gen.sv
module frs_pulse_gen #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          line_tick,
   input  logic [LW-1:0] width,
   input  logic          active_high,
   output logic          active,
   output logic          pin
);

   if (LW < 2) begin : g_bad_lw
      $error("frs_pulse_gen: LW must be at least 2");
   end

   logic [LW-1:0] left_q;
   logic          act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         left_q <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         left_q <= width;
      end else if (act_q && line_tick) begin
         if (left_q <= {{(LW-1){1'b0}}, 1'b1}) act_q <= 1'b0;
         left_q <= left_q - 1'b1;
      end
   end

   assign active = act_q;
   assign pin    = active_high ? act_q : ~act_q;

   AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !line_tick && !start) |=> act_q);  // R4

endmodule

// File: rtl/frs_line_seq.sv
module frs_line_seq
   import frs_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig_edge,
   input  logic          arm,
   input  logic          line_tick,
   input  logic [1:0]    mode,
   input  logic [LW-1:0] froff,
   input  logic [LW-1:0] voff,
   input  logic [LW-1:0] active,
   input  logic [LW-1:0] strobe_line,
   input  logic [LW-1:0] field_lines,
   output logic          go,
   output logic          acq,
   output logic          strobe,
   output logic          busy,
   output logic          armed
);

   localparam int CW = LW + 1;

   seq_state_t    state_q;
   logic [LW-1:0] dly_q;
   logic [LW-1:0] line_q;
   logic [1:0]    fld_q;

   logic          line_last;
   logic          fld_last;
   logic [CW-1:0] win_end;

   assign go        = trig_edge && arm && (state_q == SEQ_IDLE);
   assign line_last = (line_q == field_lines - 1'b1);
   assign fld_last  = (fld_q == last_field(mode));
   assign win_end   = {1'b0, voff} + {1'b0, active};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         dly_q   <= '0;
         line_q  <= '0;
         fld_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (go) begin
               line_q <= '0;
               fld_q  <= '0;
               dly_q  <= froff;
               state_q <= (froff == '0) ? SEQ_RUN : SEQ_DELAY;
            end
            SEQ_DELAY: if (line_tick) begin
               if (dly_q <= {{(LW-1){1'b0}}, 1'b1}) state_q <= SEQ_RUN;
               dly_q <= dly_q - 1'b1;
            end
            SEQ_RUN: if (line_tick) begin
               if (line_last) begin
                  line_q <= '0;
                  if (fld_last) state_q <= SEQ_IDLE;
                  else          fld_q   <= fld_q + 1'b1;
               end else begin
                  line_q <= line_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      acq    = 1'b0;
      strobe = 1'b0;
      if (state_q == SEQ_RUN) begin
         acq    = field_captured(mode, fld_q) && (line_q >= voff)
                  && ({1'b0, line_q} < win_end);
         strobe = (fld_q == 2'd0) && (line_q == strobe_line);
      end
   end

   assign busy  = (state_q != SEQ_IDLE);
   assign armed = arm && (state_q == SEQ_IDLE);

   AST_GO_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> busy);  // R2
   AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !line_tick) |=> busy);  // R5
   AST_LINE_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RUN) |-> (line_q < field_lines));  // R6
   AST_STROBE_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && line_tick) |=> !strobe);  // R8
   AST_IGNORE_BUSY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig_edge) |-> !go);  // R9

endmodule

// File: rtl/frame_reset_sequencer.sv
module frame_reset_sequencer #(
   parameter int LW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit TRIG_RISING = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig_in,
   input  logic          line_tick,
   input  logic          cfg_arm,
   input  logic [1:0]    cfg_mode,
   input  logic          cfg_wide_pulse,
   input  logic          cfg_pulse_pol,
   input  logic [LW-1:0] cfg_froff,
   input  logic [LW-1:0] cfg_voff,
   input  logic [LW-1:0] cfg_active,
   input  logic [LW-1:0] cfg_strobe_line,
   input  logic [LW-1:0] cfg_field_lines,
   output logic          frst_out,
   output logic          vs_reset,
   output logic          strobe_out,
   output logic          acq_en,
   output logic          st_armed,
   output logic          st_busy
);

   localparam logic [LW-1:0] ONE_LINE = {{(LW-1){1'b0}}, 1'b1};

   logic          trig_edge;
   logic          go;
   logic          pulse_act;
   logic [LW-1:0] pulse_len;

   assign pulse_len = (cfg_wide_pulse && cfg_froff != '0) ? cfg_froff : ONE_LINE;

   frs_trig_sync #(.STAGES(SYNC_STAGES), .TRIG_RISING(TRIG_RISING)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_in  (trig_in),
      .edge_seen (trig_edge)
   );

   frs_line_seq #(.LW(LW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_edge   (trig_edge),
      .arm         (cfg_arm),
      .line_tick   (line_tick),
      .mode        (cfg_mode),
      .froff       (cfg_froff),
      .voff        (cfg_voff),
      .active      (cfg_active),
      .strobe_line (cfg_strobe_line),
      .field_lines (cfg_field_lines),
      .go          (go),
      .acq         (acq_en),
      .strobe      (strobe_out),
      .busy        (st_busy),
      .armed       (st_armed)
   );

   frs_pulse_gen #(.LW(LW)) u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (go),
      .line_tick   (line_tick),
      .width       (pulse_len),
      .active_high (cfg_pulse_pol),
      .active      (pulse_act),
      .pin         (frst_out)
   );

   assign vs_reset = pulse_act;

   AST_START_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_busy) |-> pulse_act);  // R3
   AST_PULSE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_act |-> st_busy);  // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !st_busy |-> (!acq_en && !strobe_out));  // R7

endmodule

// File: tb/frame_reset_sequencer_bench.sv
module frame_reset_sequencer_bench;

   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_in = 1'b0;
   logic          line_tick = 1'b0;
   logic          cfg_arm = 1'b0;
   logic [1:0]    cfg_mode = '0;
   logic          cfg_wide_pulse = 1'b0;
   logic          cfg_pulse_pol = 1'b1;
   logic [LW-1:0] cfg_froff = '0;
   logic [LW-1:0] cfg_voff = '0;
   logic [LW-1:0] cfg_active = '0;
   logic [LW-1:0] cfg_strobe_line = '0;
   logic [LW-1:0] cfg_field_lines = 8'd4;
   logic          frst_out, vs_reset, strobe_out, acq_en, st_armed, st_busy;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   frame_reset_sequencer #(.LW(LW)) u_frame_reset_sequencer (
      .clk (clk), .rst_n (rst_n), .trig_in (trig_in), .line_tick (line_tick),
      .cfg_arm (cfg_arm), .cfg_mode (cfg_mode), .cfg_wide_pulse (cfg_wide_pulse),
      .cfg_pulse_pol (cfg_pulse_pol), .cfg_froff (cfg_froff), .cfg_voff (cfg_voff),
      .cfg_active (cfg_active), .cfg_strobe_line (cfg_strobe_line),
      .cfg_field_lines (cfg_field_lines), .frst_out (frst_out), .vs_reset (vs_reset),
      .strobe_out (strobe_out), .acq_en (acq_en), .st_armed (st_armed), .st_busy (st_busy)
   );

   // columns: froff wide mode voff active strobe len pol |
   //          exp_pulse exp_strobe_line exp_acq_first exp_acq_count exp_busy
   localparam int NV = 5;
   localparam int TBL [0:NV-1][0:12] = '{
      '{3, 0, 0, 2, 4, 1, 8, 1,  1, 4, 5, 4, 11},
      '{3, 1, 1, 1, 3, 0, 6, 0,  3, 3, 4, 6, 15},
      '{0, 1, 2, 2, 2, 5, 7, 1,  1, 5, 9, 4, 21},
      '{5, 1, 0, 0, 6, 2, 6, 0,  5, 7, 5, 6, 11},
      '{1, 0, 3, 3, 2, 0, 5, 1,  1, 1, 4, 2, 6}
   };

   int m_pulse, m_sat, m_scnt, m_afirst, m_acnt, m_busy, m_vsbad;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply_cfg(input int v);
      cfg_froff       = LW'(TBL[v][0]);
      cfg_wide_pulse  = TBL[v][1][0];
      cfg_mode        = TBL[v][2][1:0];
      cfg_voff        = LW'(TBL[v][3]);
      cfg_active      = LW'(TBL[v][4]);
      cfg_strobe_line = LW'(TBL[v][5]);
      cfg_field_lines = LW'(TBL[v][6]);
      cfg_pulse_pol   = TBL[v][7][0];
   endtask

   task automatic tick();
      @(negedge clk) line_tick = 1'b1;
      @(negedge clk) line_tick = 1'b0;
   endtask

   task automatic sample(input int i);
      bit act;
      act = (frst_out == cfg_pulse_pol);
      if (act) m_pulse++;
      if (vs_reset != act) m_vsbad++;
      if (strobe_out) begin
         m_scnt++;
         if (m_sat < 0) m_sat = i;
      end
      if (acq_en) begin
         m_acnt++;
         if (m_afirst < 0) m_afirst = i;
      end
      if (st_busy) m_busy++;
   endtask

   task automatic run_cycle(input int nt, input int retrig_at, input bit keep_high);
      m_pulse = 0; m_sat = -1; m_scnt = 0; m_afirst = -1; m_acnt = 0; m_busy = 0; m_vsbad = 0;
      @(negedge clk) trig_in = 1'b1;
      repeat (3) @(negedge clk);
      sample(0);
      for (int i = 1; i <= nt; i++) begin
         if (i == retrig_at) begin
            trig_in = 1'b0;
            repeat (4) @(negedge clk);
            trig_in = 1'b1;
            repeat (4) @(negedge clk);
         end
         tick();
         sample(i);
      end
      if (!keep_high) begin
         trig_in = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      cfg_arm = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R10: reset state
      check(!st_busy && !acq_en && !strobe_out && !vs_reset, "R1 idle outputs",
            {st_busy, acq_en, strobe_out, vs_reset}, 0);
      check(frst_out == 1'b0, "R1 pulse inactive level", frst_out, 0);
      check(st_armed == 1'b1, "R10 armed when idle", st_armed, 1);

      // table of capture cycles: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         apply_cfg(v);
         @(negedge clk);
         run_cycle(TBL[v][12] + 2, -1, 1'b0);
         check(m_pulse == TBL[v][8], "R4 pulse width", m_pulse, TBL[v][8]);
         check(m_vsbad == 0, "R3 vs_reset tracks pulse", m_vsbad, 0);
         check(m_sat == TBL[v][9] && m_scnt == 1, "R8 strobe line", m_sat, TBL[v][9]);
         check(m_afirst == TBL[v][10], "R7 acquire start", m_afirst, TBL[v][10]);
         check(m_acnt == TBL[v][11], "R7 acquire lines", m_acnt, TBL[v][11]);
         check(m_busy == TBL[v][12], "R5 R6 busy lines", m_busy, TBL[v][12]);
      end

      // R2 / R3 / R10: latency of the trigger path, active-high pulse
      apply_cfg(0);
      @(negedge clk) trig_in = 1'b1;
      repeat (2) @(negedge clk);
      check(!st_busy && frst_out == 1'b0, "R2 not busy after two edges", st_busy, 0);
      @(negedge clk);
      check(st_busy == 1'b1, "R2 busy on third edge", st_busy, 1);
      check(frst_out == 1'b1 && vs_reset, "R3 pulse with busy", frst_out, 1);
      check(st_armed == 1'b0, "R10 armed drops while busy", st_armed, 0);
      for (int i = 0; i < TBL[0][12]; i++) tick();
      check(st_busy == 1'b0, "R10 busy clears at end", st_busy, 0);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);

      // R2: disarmed trigger ignored
      cfg_arm = 1'b0;
      @(negedge clk);
      check(st_armed == 1'b0, "R10 not armed when disabled", st_armed, 0);
      trig_in = 1'b1;
      repeat (6) @(negedge clk);
      for (int i = 0; i < 3; i++) tick();
      check(!st_busy && frst_out == 1'b0, "R2 disarmed trigger ignored", st_busy, 0);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
      cfg_arm = 1'b1;

      // R9: retrigger mid-cycle is ignored
      apply_cfg(0);
      @(negedge clk);
      run_cycle(TBL[0][12] + 2, 4, 1'b0);
      check(m_busy == TBL[0][12], "R9 retrigger keeps length", m_busy, TBL[0][12]);
      check(m_pulse == 1, "R9 retrigger no new pulse", m_pulse, 1);
      check(m_acnt == TBL[0][11], "R9 retrigger acquire", m_acnt, TBL[0][11]);

      // R9: trigger held high past the end does not restart
      run_cycle(TBL[0][12], -1, 1'b1);
      check(m_busy == TBL[0][12], "R9 held cycle length", m_busy, TBL[0][12]);
      repeat (6) @(negedge clk);
      for (int i = 0; i < 3; i++) tick();
      check(!st_busy && frst_out == 1'b0, "R9 held trigger no restart", st_busy, 0);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule